// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block keeps the status register of a serial flash memory and decides whether each modifying request may run. The serial front end decodes commands and hands the block one-cycle strobes: set or clear the write enable latch, write the status register, program a page, erase a sector, or erase the whole device. A program or sector erase also comes with its 20-bit target address. The block also watches the external write-protect pin, which is active low.

For every status write, program or erase strobe, the block gives one answer in the following cycle: a one-cycle grant or a one-cycle deny. A granted operation starts a busy timer. Each operation type has its own cycle count, set by a parameter. The write-in-progress bit follows that timer, so software can poll the status byte until the operation ends. The protection state lives in plain registers. The memory array is not part of this block.

Protection works in layers. Nothing is granted unless the write enable latch was set beforehand. A three-bit block-protect field shields a range of sectors, counted down from the top sector. A status-register-write-disable bit, together with a low write-protect pin, makes that field and the disable bit itself read-only.

Top module: `fsr_guard`

## Requirements
- R1: The status byte is laid out as bit 0 = write-in-progress, bit 1 = write enable latch, bits 4:2 = block-protect field, bit 7 = status-write-disable, and bits 6:5 = always 0. After reset the byte reads 0x00, and grant, deny and busy are low.
- R2: When the block is idle, an enable strobe sets bit 1 of the status byte and a disable strobe clears it. The new value is visible one cycle after the strobe.
- R3: A status write, page program, sector erase or bulk erase that arrives while the write enable latch is 0 is denied.
- R4: A page program or sector erase is denied when its sector (address bits 19:16) is protected. The protected sectors for each block-protect value are: 000 = none; 001 = sector 15; 010 = sectors 14-15; 011 = sectors 12-15; 100 = sectors 8-15; 101, 110 and 111 = all 16 sectors.
- R5: A bulk erase is granted only when the block-protect field is 000. With any other value it is denied.
- R6: A status write is denied when the status-write-disable bit is 1 and the write-protect pin is low. In that case the block-protect field and the disable bit keep their values. When the pin is high, the write is allowed.
- R7: A deny clears the write enable latch.
- R8: Grant and deny are one-cycle pulses that appear in the cycle after the strobe, and never together. After a grant, busy and write-in-progress stay high for exactly the operation's cycle count: 8 for status write, 12 for page program, 24 for sector erase and 40 for bulk erase, with the default parameters.
- R9: When a granted operation finishes, the write enable latch clears. For a status write, the new values of bits 7 and 4:2 become visible at the same moment that busy falls.
- R10: While busy is high, every strobe is ignored: no grant, no deny, and no change to the write enable latch.
- R11: When several request strobes arrive in the same cycle, only one is served, in the order status write, bulk erase, sector erase, page program. A request strobe also takes precedence over an enable or disable strobe in the same cycle, and that enable or disable strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wren_i | input | 1 | Strobe: set the write enable latch |
| wrdi_i | input | 1 | Strobe: clear the write enable latch |
| wrsr_i | input | 1 | Strobe: status write request |
| wrsr_data_i | input | 8 | New status byte; only bits 7 and 4:2 are used |
| pp_i | input | 1 | Strobe: page program request |
| se_i | input | 1 | Strobe: sector erase request |
| be_i | input | 1 | Strobe: bulk erase request |
| addr_i | input | 20 | Target byte address for program or sector erase |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | One-cycle pulse: request accepted |
| deny_o | output | 1 | One-cycle pulse: request refused |
| busy_o | output | 1 | An accepted operation is running |

## Verification
A write enable latch stuck in the wrong state shows up on the very next request, because the grant or deny pulse one cycle later comes out inverted. The bit also reads wrong in status bit 1 at once. A block-protect decode error only shows when a request targets a sector near a range boundary, so the bench sweeps every protect value against sectors on both sides of each boundary. A timer off by one cycle shows only as a busy window of the wrong length, so the window is counted against each operation's cycle count. A status write that is applied too early or too late shows as the protect field changing out of step with the fall of busy.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_WRSR = 3'd1,
        OP_PP   = 3'd2,
        OP_SE   = 3'd3,
        OP_BE   = 3'd4
    } op_e;

    localparam int BP_W = 3;

    typedef struct packed {
        logic            srwd;
        logic [1:0]      rsvd;
        logic [BP_W-1:0] bp;
        logic            wel;
        logic            wip;
    } status_t;

    // Protected range grows downward from the top sector:
    // code k (1..sect_w) shields the top 2^(k-1) sectors, larger codes shield all.
    function automatic logic sector_locked(input logic [BP_W-1:0] bp,
                                           input int sector,
                                           input int sect_w);
        int code;
        code = int'(bp);
        if (code == 0)
            return 1'b0;
        if (code - 1 >= sect_w)
            return 1'b1;
        return sector >= ((1 << sect_w) - (1 << (code - 1)));
    endfunction

endpackage

// File: rtl/fsr_protect_decode.sv
module fsr_protect_decode
    import fsr_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  op_e              op,
    input  logic [BP_W-1:0]  bp,
    input  logic             srwd,
    input  logic             wp_n,
    input  logic [SECT_W-1:0] sector,
    output logic             locked
);
    always_comb begin
        unique case (op)
            OP_WRSR: locked = srwd && !wp_n;
            OP_BE:   locked = (bp != '0);
            OP_PP,
            OP_SE:   locked = sector_locked(bp, int'(sector), SECT_W);
            default: locked = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer
    import fsr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int T_WRSR = 8,
    parameter int T_PP   = 12,
    parameter int T_SE   = 24,
    parameter int T_BE   = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  op,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (op)
            OP_WRSR: load_val = CNT_W'(T_WRSR - 1);
            OP_PP:   load_val = CNT_W'(T_PP - 1);
            OP_SE:   load_val = CNT_W'(T_SE - 1);
            OP_BE:   load_val = CNT_W'(T_BE - 1);
            default: load_val = '0;
        endcase
    end

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0)
                busy <= 1'b0;
            else
                remain <= remain - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= load_val;
        end
    end
endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 4,
    parameter int CNT_W  = 16,
    parameter int T_WRSR = 8,
    parameter int T_PP   = 12,
    parameter int T_SE   = 24,
    parameter int T_BE   = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              pp_i,
    input  logic              se_i,
    input  logic              be_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              deny_o,
    output logic              busy_o
);
    localparam int SECT_LSB = ADDR_W - SECT_W;

    op_e              req_op;
    logic             busy, done, locked, accept, refuse, has_req;
    logic             wel, srwd, pend_valid, pend_srwd;
    logic [BP_W-1:0]  bp, pend_bp;
    logic [SECT_W-1:0] sector;
    status_t          st;

    wire unused_bits = ^{wrsr_data_i[6:5], wrsr_data_i[1:0], addr_i[SECT_LSB-1:0]};

    assign sector = addr_i[ADDR_W-1:SECT_LSB];

    // Fixed service order for coincident requests
    always_comb begin
        if (wrsr_i)      req_op = OP_WRSR;
        else if (be_i)   req_op = OP_BE;
        else if (se_i)   req_op = OP_SE;
        else if (pp_i)   req_op = OP_PP;
        else             req_op = OP_NONE;
    end

    fsr_protect_decode #(.SECT_W(SECT_W)) decode_i (
        .op     (req_op),
        .bp     (bp),
        .srwd   (srwd),
        .wp_n   (wp_n_i),
        .sector (sector),
        .locked (locked)
    );

    assign has_req = (req_op != OP_NONE) && !busy;
    assign accept  = has_req && wel && !locked;
    assign refuse  = has_req && !(wel && !locked);

    fsr_busy_timer #(
        .CNT_W (CNT_W),
        .T_WRSR(T_WRSR),
        .T_PP  (T_PP),
        .T_SE  (T_SE),
        .T_BE  (T_BE)
    ) timer_i (
        .clk  (clk),
        .rst  (rst),
        .start(accept),
        .op   (req_op),
        .busy (busy),
        .done (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel        <= 1'b0;
            srwd       <= 1'b0;
            bp         <= '0;
            pend_valid <= 1'b0;
            pend_srwd  <= 1'b0;
            pend_bp    <= '0;
            grant_o    <= 1'b0;
            deny_o     <= 1'b0;
        end else begin
            grant_o <= accept;
            deny_o  <= refuse;
            if (done) begin
                wel <= 1'b0;
                if (pend_valid) begin
                    srwd       <= pend_srwd;
                    bp         <= pend_bp;
                    pend_valid <= 1'b0;
                end
            end else if (!busy) begin
                if (req_op != OP_NONE) begin
                    if (refuse)
                        wel <= 1'b0;
                    if (accept && req_op == OP_WRSR) begin
                        pend_valid <= 1'b1;
                        pend_srwd  <= wrsr_data_i[7];
                        pend_bp    <= wrsr_data_i[4:2];
                    end
                end else if (wrdi_i) begin
                    wel <= 1'b0;
                end else if (wren_i) begin
                    wel <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        st.srwd = srwd;
        st.rsvd = 2'b00;
        st.bp   = bp;
        st.wel  = wel;
        st.wip  = busy;
    end

    assign status_o = st;
    assign busy_o   = busy;
endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] status,
    input logic       grant,
    input logic       deny,
    input logic       busy,
    input logic       cmd_be,
    input logic       cmd_wrsr,
    input logic       wp_n
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        status[6:5] == 2'b00);

    a_r8_grant_deny_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(grant && deny));

    a_r8_grant_starts_busy: assert property (@(posedge clk) disable iff (rst)
        grant |-> (busy && status[0]));

    a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (rst)
        grant |-> $past(status[1]));

    a_r7_deny_clears_wel: assert property (@(posedge clk) disable iff (rst)
        deny |-> !status[1]);

    a_r10_silent_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!grant && !deny));

    a_r9_finish_clears_wel: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !status[1]);

    a_r6_hw_lock_freezes: assert property (@(posedge clk) disable iff (rst)
        (!busy && status[7] && !wp_n) |=> (status[7:2] == $past(status[7:2])));

    a_r5_be_needs_clear_bp: assert property (@(posedge clk) disable iff (rst)
        (cmd_be && !cmd_wrsr && !busy && status[4:2] != 3'b000) |=> deny);
endmodule

bind fsr_guard fsr_guard_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .status  (status_o),
    .grant   (grant_o),
    .deny    (deny_o),
    .busy    (busy_o),
    .cmd_be  (be_i),
    .cmd_wrsr(wrsr_i),
    .wp_n    (wp_n_i)
);

// File: tb/fsr_guard_tb_top.sv
module fsr_guard_tb_top;
    localparam int T_WRSR = 8;
    localparam int T_PP   = 12;
    localparam int T_SE   = 24;
    localparam int T_BE   = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wren_i = 0, wrdi_i = 0, wrsr_i = 0, pp_i = 0, se_i = 0, be_i = 0;
    logic [7:0]  wrsr_data_i = '0;
    logic [19:0] addr_i = '0;
    logic        wp_n_i = 1'b1;
    logic [7:0]  status_o;
    logic        grant_o, deny_o, busy_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fsr_guard #(
        .T_WRSR(T_WRSR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE)
    ) dut_i (
        .clk(clk), .rst(rst), .wren_i(wren_i), .wrdi_i(wrdi_i),
        .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .pp_i(pp_i),
        .se_i(se_i), .be_i(be_i), .addr_i(addr_i), .wp_n_i(wp_n_i),
        .status_o(status_o), .grant_o(grant_o), .deny_o(deny_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle strobe; returns at the falling edge after the sampling edge
    task automatic drive(input bit en, input bit dis, input bit sw, input bit prg,
                         input bit ser, input bit bul, input logic [7:0] d,
                         input logic [19:0] a);
        @(negedge clk);
        wren_i = en; wrdi_i = dis; wrsr_i = sw; pp_i = prg; se_i = ser; be_i = bul;
        wrsr_data_i = d; addr_i = a;
        @(negedge clk);
        wren_i = 0; wrdi_i = 0; wrsr_i = 0; pp_i = 0; se_i = 0; be_i = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_status(input logic [7:0] v);
        int n;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 1, 0, 0, 0, v, 20'h0);
        wait_idle(n);
    endtask

    function automatic bit exp_locked(input int bp, input int sec);
        int lo;
        case (bp)
            0: lo = 16;
            1: lo = 15;
            2: lo = 14;
            3: lo = 12;
            4: lo = 8;
            default: lo = 0;
        endcase
        return sec >= lo;
    endfunction

    task automatic t_reset;
        check("R1 reset status", status_o, 8'h00);
        check("R1 reset grant", grant_o, 0);
        check("R1 reset deny", deny_o, 0);
        check("R1 reset busy", busy_o, 0);
    endtask

    task automatic t_latch;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        check("R2 enable sets latch", status_o[1], 1);
        drive(0, 1, 0, 0, 0, 0, 8'h00, 20'h0);
        check("R2 disable clears latch", status_o[1], 0);
    endtask

    task automatic t_no_wel;
        drive(0, 0, 0, 1, 0, 0, 8'h00, 20'h0);
        check("R3 program without latch denied", deny_o, 1);
        check("R3 program without latch no grant", grant_o, 0);
        drive(0, 0, 1, 0, 0, 0, 8'h0C, 20'h0);
        check("R3 status write without latch denied", deny_o, 1);
        check("R3 status unchanged", status_o, 8'h00);
    endtask

    task automatic t_status_write;
        int n;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 1, 0, 0, 0, 8'h0C, 20'h0);
        check("R8 status write grant", grant_o, 1);
        check("R9 field held until done", status_o, 8'h03);
        wait_idle(n);
        check("R8 status write busy cycles", n, T_WRSR);
        check("R9 status after write", status_o, 8'h0C);
        set_status(8'h00);
    endtask

    task automatic t_sweep;
        int secs[8] = '{0, 7, 8, 11, 12, 13, 14, 15};
        int n;
        for (int bp = 0; bp < 8; bp++) begin
            set_status(8'(bp << 2));
            check("R9 field written", status_o, 32'(bp << 2));
            for (int i = 0; i < 8; i++) begin
                bit lk;
                lk = exp_locked(bp, secs[i]);
                drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
                drive(0, 0, 0, 1, 0, 0, 8'h00, {4'(secs[i]), 16'h1234});
                check($sformatf("R4 grant bp=%0d sec=%0d", bp, secs[i]), grant_o, !lk);
                check($sformatf("R4 deny bp=%0d sec=%0d", bp, secs[i]), deny_o, lk);
                if (lk)
                    check("R7 deny clears latch", status_o[1], 0);
                wait_idle(n);
                if (!lk && bp == 0 && i == 0)
                    check("R8 program busy cycles", n, T_PP);
                check("R9 latch clear after op", status_o[1], 0);
            end
        end
        set_status(8'h08);
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 0, 0, 1, 0, 8'h00, 20'hF0000);
        check("R4 sector erase top denied bp=010", deny_o, 1);
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 0, 0, 1, 0, 8'h00, 20'hD0000);
        check("R4 sector erase sec13 granted bp=010", grant_o, 1);
        wait_idle(n);
        check("R8 sector erase busy cycles", n, T_SE);
        set_status(8'h00);
    endtask

    task automatic t_bulk;
        int n;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 0, 0, 0, 1, 8'h00, 20'h0);
        check("R5 bulk erase granted bp=000", grant_o, 1);
        wait_idle(n);
        check("R8 bulk erase busy cycles", n, T_BE);
        set_status(8'h04);
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 0, 0, 0, 1, 8'h00, 20'h0);
        check("R5 bulk erase denied bp=001", deny_o, 1);
        check("R7 latch cleared", status_o[1], 0);
        set_status(8'h00);
    endtask

    task automatic t_hw_lock;
        int n;
        set_status(8'h84);
        check("R6 lock setup", status_o, 8'h84);
        wp_n_i = 1'b0;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 1, 0, 0, 0, 8'h00, 20'h0);
        check("R6 locked status write denied", deny_o, 1);
        check("R6 locked field kept", status_o, 8'h84);
        wp_n_i = 1'b1;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 1, 0, 0, 0, 8'h00, 20'h0);
        check("R6 pin high status write granted", grant_o, 1);
        wait_idle(n);
        check("R6 field cleared after unlock", status_o, 8'h00);
    endtask

    task automatic t_busy_ignore;
        int n;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 0, 0, 1, 0, 8'h00, 20'h10000);
        check("R10 erase granted", grant_o, 1);
        drive(0, 1, 0, 0, 0, 0, 8'h00, 20'h0);
        check("R10 disable ignored while busy", status_o[1], 1);
        drive(0, 0, 0, 1, 0, 0, 8'h00, 20'h0);
        check("R10 no grant while busy", grant_o, 0);
        check("R10 no deny while busy", deny_o, 0);
        check("R10 latch unchanged", status_o[1], 1);
        wait_idle(n);
        check("R9 latch clear at end", status_o[1], 0);
    endtask

    task automatic t_priority;
        int n;
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 0, 1, 1, 1, 8'h00, 20'h0);
        check("R11 one grant for three", grant_o, 1);
        wait_idle(n);
        check("R11 bulk erase wins", n, T_BE);
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 0, 1, 0, 0, 1, 8'h00, 20'h0);
        wait_idle(n);
        check("R11 status write wins", n, T_WRSR);
        drive(1, 0, 0, 1, 0, 0, 8'h00, 20'h0);
        check("R11 request over enable denied", deny_o, 1);
        check("R11 enable dropped", status_o[1], 0);
        drive(1, 0, 0, 0, 0, 0, 8'h00, 20'h0);
        drive(0, 1, 0, 0, 1, 0, 8'h00, 20'h0);
        check("R11 request over disable granted", grant_o, 1);
        wait_idle(n);
        check("R11 erase length", n, T_SE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_wel();
        t_status_write();
        t_sweep();
        t_bulk();
        t_hw_lock();
        t_busy_ignore();
        t_priority();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule